// File: doc/BRIEF.md
# Region-Based Bus Access Permission Filter

This block sits beside the bus fabric and rules on every access from four independent access paths. Each access carries an address, the ID of the requesting master and an access type (read, write or execute). A table maps each master to one of four secure modes. Mode 0 is trusted. Modes 1 to 3 are restricted and are checked against a table of sixteen address regions. Each region holds an inclusive start and end address, an enable bit, and a three-bit rights field for each restricted mode.

The grant or block decision is combinational and comes out in the same cycle as the access. A blocked access is logged at the next clock edge in that path's exception record. The record holds a status bit, the master ID, the secure mode, the region number, a no-match flag and the faulting address. It stays frozen until software clears it. The interrupt output combines the status bits of the paths whose interrupt enable is set.

All configuration goes through a word-addressed write port with a combinational read-back. A write takes effect at the next clock edge.

Top module: `acc_perm_filter`

## Requirements
- R1: After reset, every register reads 0, every exception status is 0 and irq_o is low. Because every path filter is then off, every access is granted.
- R2: Register map, in byte offsets. Region r uses three words: start at 12·r, end at 12·r+4 and rights at 12·r+8. The rights word holds the rights of mode k in bits [4(k−1)+2 : 4(k−1)], and every other bit reads 0. Region enable is at 0x0C0, one bit per region. Path filter enable is at 0x0C4 (bit p). Path interrupt enable is at 0x0C8 (bit p). Any offset not listed here reads 0.
- R3: An access is granted with no check when the master's mode is 0 or when the filter of its path is disabled.
- R4: A region covers an address when start ≤ address ≤ end, both bounds inclusive. A region whose enable bit is 0 never covers any address.
- R5: When several enabled regions cover the address, the region with the lowest number decides.
- R6: A restricted-mode access on a filtered path that no enabled region covers is blocked.
- R7: Within the rights field of the deciding region, bit 0 grants read (type 0), bit 1 grants write (type 1) and bit 2 grants execute (type 2). Type 3 is never granted in a restricted mode.
- R8: Master m takes its secure mode from bits [1:0] of the word at 0x200+4·m, which reads back the same value.
- R9: A blocked access on path p sets that path's status at the next clock edge. Path p's words are: status at 0x100+16·p (bit 0), clear at +4, info at +8, and faulting address at +12. The info word holds the master ID in [4:0], the mode in [9:8], the region in [19:16], and the no-match flag in bit 20 (region field 0 when the flag is set).
- R10: While a path's status is set, later blocked accesses on that path leave its info and address unchanged.
- R11: Writing 1 to bit 0 of a path's clear word clears its status at the next edge. If a blocked access arrives on that path in the same cycle, the clear wins and the access is not logged.
- R12: irq_o is high exactly when some path has both its status bit and its interrupt-enable bit set.
- R13: acc_grant_o[p] is high when path p is valid and allowed, and acc_block_o[p] is high when path p is valid and denied. Both are low when the path is not valid, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 10 | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i, combinational |
| acc_valid_i | input | 4 | Access present, one bit per path |
| acc_addr_i | input | 128 | Access address, 32 bits per path |
| acc_mst_i | input | 20 | Master ID, 5 bits per path |
| acc_type_i | input | 8 | Access type, 2 bits per path (0 read, 1 write, 2 execute) |
| acc_grant_o | output | 4 | Access allowed, per path |
| acc_block_o | output | 4 | Access blocked, per path |
| irq_o | output | 1 | Exception interrupt |

## Verification
The assertions assume that the access inputs are stable over the whole cycle in which they are sampled. They also assume that region bounds are not rewritten while an access that depends on them is being decided. The bench keeps to both rules: it changes the configuration and the access inputs only at falling edges, and it never writes configuration while an access is being checked. The type code 3 and the no-match case are driven on purpose, so the assertions on the deny path are exercised by real traffic. A clear write is made to coincide with a violation only in the one cycle set aside to check R11.

// File: rtl/apf_pkg.sv
package apf_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_type_e;

  localparam int RGN_STRIDE   = 12;
  localparam int OFF_RGN_EN   = 'h0C0;
  localparam int OFF_PATH_EN  = 'h0C4;
  localparam int OFF_IRQ_EN   = 'h0C8;
  localparam int OFF_EXC_BASE = 'h100;
  localparam int EXC_STRIDE   = 'h10;
  localparam int OFF_MST_BASE = 'h200;
  localparam int NSLOT        = 3;    // restricted modes
  localparam int SLOT_STRIDE  = 4;

  localparam int INFO_MODE_LSB = 8;
  localparam int INFO_RGN_LSB  = 16;
  localparam int INFO_MISS_BIT = 20;
endpackage

// File: rtl/apf_cfg.sv
module apf_cfg
  import apf_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int NPATH = 4,
  parameter int NMST  = 32,
  parameter int AW    = 32,
  parameter int CAW   = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CAW-1:0]       addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [AW-1:0]        rgn_start_o [NREG],
  output logic [AW-1:0]        rgn_end_o   [NREG],
  output logic [NSLOT-1:0][2:0] rgn_perm_o [NREG],
  output logic [NREG-1:0]      rgn_en_o,
  output logic [NPATH-1:0]     path_en_o,
  output logic [NPATH-1:0]     irq_en_o,
  output logic [1:0]           mst_mode_o  [NMST],
  input  logic [NPATH-1:0]     exc_stat_i,
  input  logic [31:0]          exc_info_i  [NPATH],
  input  logic [AW-1:0]        exc_addr_i  [NPATH],
  output logic [NPATH-1:0]     exc_clr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) begin
        rgn_start_o[r] <= '0;
        rgn_end_o[r]   <= '0;
        rgn_perm_o[r]  <= '0;
      end
      for (int m = 0; m < NMST; m++) mst_mode_o[m] <= '0;
      rgn_en_o  <= '0;
      path_en_o <= '0;
      irq_en_o  <= '0;
    end else if (we_i) begin
      for (int r = 0; r < NREG; r++) begin
        if (addr_i == CAW'(RGN_STRIDE*r))     rgn_start_o[r] <= wdata_i[AW-1:0];
        if (addr_i == CAW'(RGN_STRIDE*r + 4)) rgn_end_o[r]   <= wdata_i[AW-1:0];
        if (addr_i == CAW'(RGN_STRIDE*r + 8))
          for (int s = 0; s < NSLOT; s++) rgn_perm_o[r][s] <= wdata_i[SLOT_STRIDE*s +: 3];
      end
      for (int m = 0; m < NMST; m++)
        if (addr_i == CAW'(OFF_MST_BASE + 4*m)) mst_mode_o[m] <= wdata_i[1:0];
      if (addr_i == CAW'(OFF_RGN_EN))  rgn_en_o  <= wdata_i[NREG-1:0];
      if (addr_i == CAW'(OFF_PATH_EN)) path_en_o <= wdata_i[NPATH-1:0];
      if (addr_i == CAW'(OFF_IRQ_EN))  irq_en_o  <= wdata_i[NPATH-1:0];
    end
  end

  always_comb begin
    for (int p = 0; p < NPATH; p++)
      exc_clr_o[p] = we_i && wdata_i[0] && (addr_i == CAW'(OFF_EXC_BASE + EXC_STRIDE*p + 4));
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (addr_i == CAW'(RGN_STRIDE*r))     rdata_o[AW-1:0] = rgn_start_o[r];
      if (addr_i == CAW'(RGN_STRIDE*r + 4)) rdata_o[AW-1:0] = rgn_end_o[r];
      if (addr_i == CAW'(RGN_STRIDE*r + 8))
        for (int s = 0; s < NSLOT; s++) rdata_o[SLOT_STRIDE*s +: 3] = rgn_perm_o[r][s];
    end
    for (int m = 0; m < NMST; m++)
      if (addr_i == CAW'(OFF_MST_BASE + 4*m)) rdata_o[1:0] = mst_mode_o[m];
    for (int p = 0; p < NPATH; p++) begin
      if (addr_i == CAW'(OFF_EXC_BASE + EXC_STRIDE*p))      rdata_o[0] = exc_stat_i[p];
      if (addr_i == CAW'(OFF_EXC_BASE + EXC_STRIDE*p + 8))  rdata_o = exc_info_i[p];
      if (addr_i == CAW'(OFF_EXC_BASE + EXC_STRIDE*p + 12)) rdata_o[AW-1:0] = exc_addr_i[p];
    end
    if (addr_i == CAW'(OFF_RGN_EN))  rdata_o[NREG-1:0]  = rgn_en_o;
    if (addr_i == CAW'(OFF_PATH_EN)) rdata_o[NPATH-1:0] = path_en_o;
    if (addr_i == CAW'(OFF_IRQ_EN))  rdata_o[NPATH-1:0] = irq_en_o;
  end

endmodule

// File: rtl/apf_check.sv
module apf_check
  import apf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NMST = 32,
  parameter int AW   = 32,
  localparam int MIDW = $clog2(NMST),
  localparam int RGW  = $clog2(NREG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [MIDW-1:0]       master_i,
  input  logic [1:0]            type_i,
  input  logic                  path_en_i,
  input  logic [AW-1:0]         rgn_start_i [NREG],
  input  logic [AW-1:0]         rgn_end_i   [NREG],
  input  logic [NSLOT-1:0][2:0] rgn_perm_i  [NREG],
  input  logic [NREG-1:0]       rgn_en_i,
  input  logic [1:0]            mst_mode_i  [NMST],
  output logic                  grant_o,
  output logic                  block_o,
  output logic [1:0]            mode_o,
  output logic                  hit_o,
  output logic [RGW-1:0]        rgn_o
);

  logic [2:0] slot;
  logic       right, bypass, allow;

  assign mode_o = mst_mode_i[master_i];

  // descending scan: last hit written is the lowest index
  always_comb begin
    hit_o = 1'b0;
    rgn_o = '0;
    for (int r = NREG-1; r >= 0; r--) begin
      if (rgn_en_i[r] && addr_i >= rgn_start_i[r] && addr_i <= rgn_end_i[r]) begin
        hit_o = 1'b1;
        rgn_o = RGW'(r);
      end
    end
  end

  always_comb begin
    slot = (mode_o == 2'd0) ? 3'b000 : rgn_perm_i[rgn_o][mode_o - 2'd1];
    unique case (acc_type_e'(type_i))
      ACC_RD:  right = slot[0];
      ACC_WR:  right = slot[1];
      ACC_EX:  right = slot[2];
      default: right = 1'b0;
    endcase
  end

  assign bypass  = !path_en_i || (mode_o == 2'd0);
  assign allow   = bypass || (hit_o && right);
  assign grant_o = valid_i && allow;
  assign block_o = valid_i && !allow;

  assert_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && block_o));
  assert_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !grant_o && !block_o);
  assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (!path_en_i || mode_o == 2'd0) |-> grant_o);
  assert_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && path_en_i && mode_o != 2'd0 && !hit_o |-> block_o);
  assert_rsv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && path_en_i && mode_o != 2'd0 && type_i == 2'd3 |-> block_o);

endmodule

// File: rtl/apf_excp.sv
module apf_excp
  import apf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NMST = 32,
  parameter int AW   = 32,
  localparam int MIDW = $clog2(NMST),
  localparam int RGW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            log_i,
  input  logic            clr_i,
  input  logic [MIDW-1:0] master_i,
  input  logic [1:0]      mode_i,
  input  logic            hit_i,
  input  logic [RGW-1:0]  rgn_i,
  input  logic [AW-1:0]   addr_i,
  output logic            stat_o,
  output logic [31:0]     info_o,
  output logic [AW-1:0]   addr_o
);

  logic [MIDW-1:0] mst_q;
  logic [1:0]      mode_q;
  logic [RGW-1:0]  rgn_q;
  logic            miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= 1'b0;
      mst_q  <= '0;
      mode_q <= '0;
      rgn_q  <= '0;
      miss_q <= 1'b0;
      addr_o <= '0;
    end else if (clr_i) begin
      stat_o <= 1'b0;
    end else if (log_i && !stat_o) begin
      stat_o <= 1'b1;
      mst_q  <= master_i;
      mode_q <= mode_i;
      rgn_q  <= hit_i ? rgn_i : '0;
      miss_q <= !hit_i;
      addr_o <= addr_i;
    end
  end

  always_comb begin
    info_o = '0;
    info_o[MIDW-1:0]               = mst_q;
    info_o[INFO_MODE_LSB +: 2]     = mode_q;
    info_o[INFO_RGN_LSB +: RGW]    = rgn_q;
    info_o[INFO_MISS_BIT]          = miss_q;
  end

  assert_log_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_i && !stat_o && !clr_i |=> stat_o);
  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o && !clr_i |=> stat_o && $stable(info_o) && $stable(addr_o));
  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !stat_o);

endmodule

// File: rtl/acc_perm_filter.sv
module acc_perm_filter
  import apf_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int NPATH = 4,
  parameter int NMST  = 32,
  parameter int AW    = 32,
  parameter int CAW   = 10,
  localparam int MIDW = $clog2(NMST),
  localparam int RGW  = $clog2(NREG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CAW-1:0]        cfg_addr_i,
  input  logic [31:0]           cfg_wdata_i,
  output logic [31:0]           cfg_rdata_o,
  input  logic [NPATH-1:0]      acc_valid_i,
  input  logic [NPATH*AW-1:0]   acc_addr_i,
  input  logic [NPATH*MIDW-1:0] acc_mst_i,
  input  logic [NPATH*2-1:0]    acc_type_i,
  output logic [NPATH-1:0]      acc_grant_o,
  output logic [NPATH-1:0]      acc_block_o,
  output logic                  irq_o
);

  logic [AW-1:0]         rgn_start [NREG];
  logic [AW-1:0]         rgn_end   [NREG];
  logic [NSLOT-1:0][2:0] rgn_perm  [NREG];
  logic [NREG-1:0]       rgn_en;
  logic [NPATH-1:0]      path_en, irq_en, exc_stat, exc_clr;
  logic [1:0]            mst_mode  [NMST];
  logic [31:0]           exc_info  [NPATH];
  logic [AW-1:0]         exc_addr  [NPATH];

  apf_cfg #(.NREG(NREG), .NPATH(NPATH), .NMST(NMST), .AW(AW), .CAW(CAW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .rgn_start_o(rgn_start), .rgn_end_o(rgn_end), .rgn_perm_o(rgn_perm), .rgn_en_o(rgn_en),
    .path_en_o(path_en), .irq_en_o(irq_en), .mst_mode_o(mst_mode),
    .exc_stat_i(exc_stat), .exc_info_i(exc_info), .exc_addr_i(exc_addr), .exc_clr_o(exc_clr)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [1:0]     mode;
    logic           hit;
    logic [RGW-1:0] rgn;

    apf_check #(.NREG(NREG), .NMST(NMST), .AW(AW)) u_check (
      .clk_i, .rst_ni,
      .valid_i(acc_valid_i[p]),
      .addr_i(acc_addr_i[p*AW +: AW]),
      .master_i(acc_mst_i[p*MIDW +: MIDW]),
      .type_i(acc_type_i[p*2 +: 2]),
      .path_en_i(path_en[p]),
      .rgn_start_i(rgn_start), .rgn_end_i(rgn_end), .rgn_perm_i(rgn_perm), .rgn_en_i(rgn_en),
      .mst_mode_i(mst_mode),
      .grant_o(acc_grant_o[p]), .block_o(acc_block_o[p]),
      .mode_o(mode), .hit_o(hit), .rgn_o(rgn)
    );

    apf_excp #(.NREG(NREG), .NMST(NMST), .AW(AW)) u_excp (
      .clk_i, .rst_ni,
      .log_i(acc_block_o[p]), .clr_i(exc_clr[p]),
      .master_i(acc_mst_i[p*MIDW +: MIDW]), .mode_i(mode), .hit_i(hit), .rgn_i(rgn),
      .addr_i(acc_addr_i[p*AW +: AW]),
      .stat_o(exc_stat[p]), .info_o(exc_info[p]), .addr_o(exc_addr[p])
    );
  end

  assign irq_o = |(exc_stat & irq_en);

  assert_irq_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (exc_stat != '0) && (irq_en != '0));
  assert_block_valid_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_block_o | acc_grant_o) & ~acc_valid_i) == '0);

endmodule

// File: tb/acc_perm_filter_tb.sv
module acc_perm_filter_tb;
  localparam int CLK_P = 10;
  localparam int NP = 4;

  logic         clk = 0, rst_n = 0;
  logic         cfg_we = 0;
  logic [9:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0, cfg_rdata;
  logic [3:0]   acc_valid = '0;
  logic [127:0] acc_addr = '0;
  logic [19:0]  acc_mst = '0;
  logic [7:0]   acc_type = '0;
  logic [3:0]   grant, block;
  logic         irq;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_st [16];
  logic [31:0] m_en [16];
  logic [31:0] m_perm [16];
  logic [15:0] m_ren = '0;
  logic [3:0]  m_pen = '0;
  logic [1:0]  m_mode [32];

  acc_perm_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_mst_i(acc_mst), .acc_type_i(acc_type),
    .acc_grant_o(grant), .acc_block_o(block), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P*150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 10'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 10'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic set_rgn(int r, logic [31:0] s, logic [31:0] e, logic [31:0] pm);
    wr(12*r, s); wr(12*r + 4, e); wr(12*r + 8, pm);
    m_st[r] = s; m_en[r] = e; m_perm[r] = pm & 32'h777;
  endtask

  task automatic acc(int p, logic [31:0] a, int m, int t, output logic g, output logic b);
    @(negedge clk);
    acc_valid = '0;
    acc_addr[p*32 +: 32] = a;
    acc_mst[p*5 +: 5] = 5'(m);
    acc_type[p*2 +: 2] = 2'(t);
    acc_valid[p] = 1'b1;
    #1 g = grant[p]; b = block[p];
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = '0;
  endtask

  function automatic bit ref_allow(int p, logic [31:0] a, int m, int t);
    int md;
    md = int'(m_mode[m]);
    if (!m_pen[p] || md == 0) return 1'b1;
    for (int r = 0; r < 16; r++)
      if (m_ren[r] && a >= m_st[r] && a <= m_en[r])
        return (t != 3) && m_perm[r][4*(md-1) + t];
    return 1'b0;
  endfunction

  logic [31:0] addrs [14] = '{32'h0FFF, 32'h1000, 32'h17FF, 32'h1800, 32'h1FFF, 32'h2000,
                              32'h27FF, 32'h2800, 32'h2FFF, 32'h3000, 32'h3001,
                              32'hEFFF_FFFF, 32'hF000_0000, 32'hFFFF_FFFF};

  initial begin
    logic g, b;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin m_st[i] = 0; m_en[i] = 0; m_perm[i] = 0; end
    for (int i = 0; i < 32; i++) m_mode[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd_chk('h0C0, 0, "R1 region enable");
    rd_chk('h0C4, 0, "R1 path enable");
    rd_chk(12*1 + 4, 0, "R1 region end");
    for (int p = 0; p < NP; p++) rd_chk('h100 + 16*p, 0, "R1 status");
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    acc(0, 32'h0, 1, 2, g, b);
    chk(g && !b, "R1 grant with filters off", {g, b}, 2'b10);
    idle();

    // configuration
    set_rgn(0, 32'h1000, 32'h1FFF, 32'h413);
    set_rgn(1, 32'h1800, 32'h27FF, 32'h074);
    set_rgn(2, 32'h3000, 32'h3000, 32'h777);
    set_rgn(15, 32'hF000_0000, 32'hFFFF_FFFF, 32'h222);
    wr('h0C0, 32'h8003); m_ren = 16'h8003;
    for (int m = 0; m < 32; m++) begin
      wr('h200 + 4*m, 32'(m % 4)); m_mode[m] = 2'(m % 4);
    end
    wr('h0C4, 32'hF); m_pen = 4'hF;

    // R2 / R8: readback
    rd_chk(12*1, 32'h1800, "R2 start word");
    rd_chk(12*1 + 4, 32'h27FF, "R2 end word");
    rd_chk(12*0 + 8, 32'h413, "R2 rights word");
    wr(12*3 + 8, 32'hFFFF_FFFF);
    rd_chk(12*3 + 8, 32'h777, "R2 rights unused bits read 0");
    rd_chk('h0C0, 32'h8003, "R2 region enable");
    rd_chk('h3FC, 0, "R2 unmapped offset");
    rd_chk('h200 + 4*5, 1, "R8 master mode word");
    rd_chk('h200 + 4*31, 3, "R8 last master mode word");

    // R3/R4/R5/R6/R7/R13 sweep
    for (int p = 0; p < NP; p++)
      for (int ai = 0; ai < 14; ai++)
        for (int m = 0; m < 8; m++)
          for (int t = 0; t < 4; t++) begin
            bit e;
            e = ref_allow(p, addrs[ai], m, t);
            acc(p, addrs[ai], m, t, g, b);
            chk(g == e && b == !e, "R3/R4/R5/R6/R7/R13 sweep", {g, b}, {e, !e});
          end
    idle();

    // R11: clear all
    for (int p = 0; p < NP; p++) wr('h104 + 16*p, 1);
    for (int p = 0; p < NP; p++) rd_chk('h100 + 16*p, 0, "R11 cleared");
    chk(irq == 0, "R12 irq low after clear", 32'(irq), 0);

    // R9: log on path 1
    wr('h0C8, 32'h2);
    acc(1, 32'h2000, 1, 0, g, b);
    chk(!g && b, "R9 blocked read in exec-only region", {g, b}, 2'b01);
    idle();
    rd_chk('h110, 1, "R9 status set");
    rd_chk('h118, 32'h0001_0101, "R9 info word");
    rd_chk('h11C, 32'h2000, "R9 fault address");
    chk(irq == 1, "R12 irq on enabled path", 32'(irq), 1);

    // R10: frozen
    acc(1, 32'h5000, 6, 1, g, b);
    idle();
    rd_chk('h118, 32'h0001_0101, "R10 info frozen");
    rd_chk('h11C, 32'h2000, "R10 address frozen");

    // R9 no-match record on path 3
    acc(3, 32'h5000, 2, 0, g, b);
    chk(!g && b, "R6 no region blocked", {g, b}, 2'b01);
    idle();
    rd_chk('h130, 1, "R9 path3 status");
    rd_chk('h138, 32'h0010_0202, "R9 no-match info");
    rd_chk('h13C, 32'h5000, "R9 path3 address");

    // R12
    wr('h114, 1);
    chk(irq == 0, "R12 irq low with only disabled path pending", 32'(irq), 0);
    wr('h0C8, 32'hA);
    chk(irq == 1, "R12 irq follows enable", 32'(irq), 1);
    wr('h0C8, 32'h0);
    chk(irq == 0, "R12 irq masked", 32'(irq), 0);

    // R11: clear beats simultaneous violation
    acc(0, 32'h5000, 1, 0, g, b);
    idle();
    rd_chk('h100, 1, "R11 precondition status");
    wr('h104, 1);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 10'h104; cfg_wdata = 1;
    acc_valid = 4'b0001; acc_addr[31:0] = 32'h6000; acc_mst[4:0] = 5'd1; acc_type[1:0] = 2'd0;
    @(negedge clk);
    cfg_we = 0; acc_valid = '0;
    rd_chk('h100, 0, "R11 clear wins over same-cycle violation");

    // R3: path filter off
    wr('h0C4, 32'hB); m_pen = 4'hB;
    acc(2, 32'h5000, 1, 1, g, b);
    chk(g && !b, "R3 path filter off grants", {g, b}, 2'b10);
    idle();
    rd_chk('h120, 0, "R3 no log on unfiltered path");
    acc(0, 32'h5000, 4, 2, g, b);
    chk(g && !b, "R3 trusted mode grants", {g, b}, 2'b10);
    idle();

    // R4: enabling a single-address region
    wr('h0C0, 32'h8007); m_ren = 16'h8007;
    acc(0, 32'h3000, 1, 0, g, b);
    chk(g && !b, "R4 single-address region covers", {g, b}, 2'b10);
    acc(0, 32'h3001, 1, 0, g, b);
    chk(!g && b, "R4 end bound inclusive only", {g, b}, 2'b01);
    idle();

    summary();
  end
endmodule